// File: doc/BRIEF.md
# Programmable Waveform Sequencer with Idle Control

This block is a compact waveform engine. Software first fills a table of seven programmable states. Each state holds a 16-bit data value, a flag that says whether that value goes onto the bus, six control levels, and the number of the state that follows. A pulse on `go` then starts the engine at state 0. The engine spends one clock in each state and follows the programmed successor from state to state. A waveform finishes when it branches to state 7, which is reserved as the idle state and can be reached from any state.

While the engine is idle, configuration registers set the pins. The data bus can either be released or keep driving the last value that a waveform put on it. The six control pins take an idle level pattern, or all of them can be released together. Each control pin can work as push-pull or as open-drain, and that choice applies both while a waveform runs and in idle.

The `done` output reports idle versus busy, and `done_irq` pulses when a waveform ends. While a waveform runs, every register write is locked out except the abort command, which stops the waveform at once.

Top module: `wfs_engine`

## Requirements
- R1: After reset the engine is idle. `done`=1, `done_irq`=0, `bus_oe`=0, `wr_err`=0. All control pins drive 0 in push-pull mode: `ctl_out`=0 and `ctl_oe`=all ones.
- R2: Register map, by write address:
  - 0: configuration. Bit 0 is the idle bus drive enable. Bit 1 is the control release mode.
  - 1: idle control levels, bits 5:0.
  - 2: pin type mask, bits 5:0.
  - 3: abort.
  - 4: error clear.
  - 8+2s: data word of state s, for s from 0 to 6.
  - 9+2s: control word of state s. Bits 2:0 are the next state, bit 3 is the bus drive flag, and bits 9:4 are the control levels.
- R3: `go` is sampled only while `done`=1. On that clock edge, `done` falls and the pins show the values of state 0.
- R4: Each state lasts one clock, and the engine then moves to its programmed next state. Branching to state 7 sets `done` and raises `done_irq` for exactly one cycle.
- R5: `go` has no effect while a waveform runs.
- R6: A write to address 3 while busy returns the engine to idle on the next edge, with `done`=1 and a one-cycle `done_irq`. The same write while idle changes nothing.
- R7: Any other write while busy is ignored and sets `wr_err`. `wr_err` stays set until a write to address 4 made while idle clears it.
- R8: In idle, `bus_oe` equals the idle bus drive enable. When that enable is 1, `bus_out` holds the last value driven by a waveform state.
- R9: The last driven value is updated only in states whose drive flag is 1. A state that does not drive the bus leaves it unchanged.
- R10: In idle with release mode 0, the control levels come from the idle control register.
- R11: In idle with release mode 1, every control pin is released: `ctl_oe`=0 and `ctl_out`=0.
- R12: For each control pin, a type bit of 0 means push-pull: `ctl_out`=level and `ctl_oe`=1. A type bit of 1 means open-drain: `ctl_out`=0 and `ctl_oe`=NOT level.
- R13: If an abort lands in the same cycle as a branch to state 7, the engine still makes exactly one `done_irq` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write address |
| wr_data | input | 16 | Register write data |
| go | input | 1 | Start a waveform |
| bus_out | output | 16 | Data bus value |
| bus_oe | output | 1 | Data bus output enable |
| ctl_out | output | 6 | Control pin values |
| ctl_oe | output | 6 | Per-pin control output enables |
| done | output | 1 | 1 when idle and ready, 0 while busy |
| done_irq | output | 1 | One-cycle pulse when a waveform ends |
| wr_err | output | 1 | Sticky flag for writes refused while busy |

## Verification
Two completion paths can fall in the same cycle: an abort write, and a programmed branch to state 7. The bench provokes this by loading a one-state program whose successor is the idle state and issuing the abort while that state is active. It then requires `done` to rise with one `done_irq` pulse, followed by a quiet cycle. A second collision is also exercised: a refused write and a `go` pulse land mid-waveform, and the engine must keep following its program while the locked-out register keeps its old value.

// File: rtl/wfs_pkg.sv
package wfs_pkg;
  // register addresses
  localparam int A_CFG     = 0;
  localparam int A_IDLECTL = 1;
  localparam int A_PINTYPE = 2;
  localparam int A_ABORT   = 3;
  localparam int A_ERRCLR  = 4;
  localparam int PROG_BASE = 8;
  // configuration bit positions
  localparam int CFG_DRV_BIT = 0;
  localparam int CFG_REL_BIT = 1;
endpackage

// File: rtl/wfs_regs.sv
module wfs_regs
  import wfs_pkg::*;
#(
  parameter int DW = 16,
  parameter int CW = 6,
  parameter int NS = 8,
  parameter int AW = 5,
  localparam int SW = $clog2(NS),
  localparam int NP = NS - 1,
  localparam int BW = SW + CW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          busy,
  input  logic [SW-1:0] rda_idx,
  input  logic [SW-1:0] rdb_idx,
  output logic [SW-1:0] rda_next,
  output logic [DW-1:0] rdb_data,
  output logic          rdb_drv,
  output logic [CW-1:0] rdb_ctl,
  output logic          cfg_drv,
  output logic          cfg_rel,
  output logic [CW-1:0] idle_ctl,
  output logic [CW-1:0] od_mask,
  output logic          abort,
  output logic          wr_err
);
  logic [DW-1:0] dmem [NP];
  logic [BW-1:0] cmem [NP];

  logic          in_prog;
  logic [AW-1:0] off_v;
  logic [SW-1:0] w_idx;
  logic          wr_ok;
  logic          hit_cfg, hit_ictl, hit_type, hit_abort, hit_clr;
  logic [SW-1:0] ia, ib;
  logic [BW-1:0] cword_b;

  always_comb begin
    off_v     = wr_addr - AW'(PROG_BASE);
    in_prog   = (int'(wr_addr) >= PROG_BASE) && (int'(wr_addr) < PROG_BASE + 2 * NP);
    w_idx     = SW'(off_v >> 1);
    wr_ok     = wr_en && !busy;
    hit_cfg   = wr_addr == AW'(A_CFG);
    hit_ictl  = wr_addr == AW'(A_IDLECTL);
    hit_type  = wr_addr == AW'(A_PINTYPE);
    hit_abort = wr_addr == AW'(A_ABORT);
    hit_clr   = wr_addr == AW'(A_ERRCLR);
    abort     = wr_en && hit_abort;
  end

  // program table: write-only port, no reset, so it maps onto RAM
  always_ff @(posedge clk) begin
    if (wr_ok && in_prog) begin
      if (off_v[0]) cmem[w_idx] <= wr_data[BW-1:0];
      else          dmem[w_idx] <= wr_data;
    end
  end

  always_comb begin
    ia       = (rda_idx < SW'(NP)) ? rda_idx : '0;
    ib       = (rdb_idx < SW'(NP)) ? rdb_idx : '0;
    rda_next = cmem[ia][SW-1:0];
    cword_b  = cmem[ib];
    rdb_drv  = cword_b[SW];
    rdb_ctl  = cword_b[SW+CW:SW+1];
    rdb_data = dmem[ib];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_drv  <= 1'b0;
      cfg_rel  <= 1'b0;
      idle_ctl <= '0;
      od_mask  <= '0;
      wr_err   <= 1'b0;
    end else begin
      if (wr_en && busy && !hit_abort) wr_err <= 1'b1;
      else if (wr_ok && hit_clr)       wr_err <= 1'b0;
      if (wr_ok && hit_cfg) begin
        cfg_drv <= wr_data[CFG_DRV_BIT];
        cfg_rel <= wr_data[CFG_REL_BIT];
      end
      if (wr_ok && hit_ictl) idle_ctl <= wr_data[CW-1:0];
      if (wr_ok && hit_type) od_mask  <= wr_data[CW-1:0];
    end
  end
endmodule

// File: rtl/wfs_seq.sv
module wfs_seq #(
  parameter int NS = 8,
  localparam int SW = $clog2(NS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic          abort,
  input  logic [SW-1:0] prog_next,
  output logic [SW-1:0] cur_q,
  output logic [SW-1:0] nxt,
  output logic          nxt_idle,
  output logic          done_q,
  output logic          irq_q
);
  localparam logic [SW-1:0] IDLE = SW'(NS - 1);

  always_comb begin
    if (cur_q == IDLE) nxt = go ? '0 : IDLE;
    else if (abort)    nxt = IDLE;
    else               nxt = prog_next;
    nxt_idle = (nxt == IDLE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q  <= IDLE;
      done_q <= 1'b1;
      irq_q  <= 1'b0;
    end else begin
      cur_q  <= nxt;
      done_q <= nxt_idle;
      irq_q  <= (cur_q != IDLE) && nxt_idle;
    end
  end
endmodule

// File: rtl/wfs_pins.sv
module wfs_pins #(
  parameter int DW = 16,
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          idle,
  input  logic [DW-1:0] st_data,
  input  logic          st_drv,
  input  logic [CW-1:0] st_ctl,
  input  logic          cfg_drv,
  input  logic          cfg_rel,
  input  logic [CW-1:0] idle_ctl,
  input  logic [CW-1:0] od_mask,
  output logic [DW-1:0] bus_out,
  output logic          bus_oe,
  output logic [CW-1:0] ctl_out,
  output logic [CW-1:0] ctl_oe
);
  logic [DW-1:0] last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_out <= '0;
      bus_oe  <= 1'b0;
      last_q  <= '0;
    end else if (idle) begin
      bus_oe  <= cfg_drv;
      bus_out <= last_q;
    end else begin
      bus_oe  <= st_drv;
      bus_out <= st_data;
      if (st_drv) last_q <= st_data;
    end
  end

  for (genvar i = 0; i < CW; i++) begin : g_pin
    logic lvl;
    always_comb lvl = idle ? idle_ctl[i] : st_ctl[i];
    always_ff @(posedge clk) begin
      if (rst) begin
        ctl_out[i] <= 1'b0;
        ctl_oe[i]  <= 1'b1;
      end else if (idle && cfg_rel) begin
        ctl_out[i] <= 1'b0;
        ctl_oe[i]  <= 1'b0;
      end else if (od_mask[i]) begin
        ctl_out[i] <= 1'b0;
        ctl_oe[i]  <= ~lvl;
      end else begin
        ctl_out[i] <= lvl;
        ctl_oe[i]  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/wfs_engine.sv
module wfs_engine #(
  parameter int DW = 16,
  parameter int CW = 6,
  parameter int NS = 8,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          go,
  output logic [DW-1:0] bus_out,
  output logic          bus_oe,
  output logic [CW-1:0] ctl_out,
  output logic [CW-1:0] ctl_oe,
  output logic          done,
  output logic          done_irq,
  output logic          wr_err
);
  localparam int SW = $clog2(NS);

  logic [SW-1:0] cur_q, nxt, prog_next;
  logic          nxt_idle, abort;
  logic [DW-1:0] st_data;
  logic          st_drv;
  logic [CW-1:0] st_ctl;
  logic          cfg_drv, cfg_rel;
  logic [CW-1:0] idle_ctl, od_mask;

  wfs_regs #(.DW(DW), .CW(CW), .NS(NS), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(~done), .rda_idx(cur_q), .rdb_idx(nxt), .rda_next(prog_next),
    .rdb_data(st_data), .rdb_drv(st_drv), .rdb_ctl(st_ctl),
    .cfg_drv(cfg_drv), .cfg_rel(cfg_rel), .idle_ctl(idle_ctl), .od_mask(od_mask),
    .abort(abort), .wr_err(wr_err)
  );

  wfs_seq #(.NS(NS)) u_seq (
    .clk(clk), .rst(rst), .go(go), .abort(abort), .prog_next(prog_next),
    .cur_q(cur_q), .nxt(nxt), .nxt_idle(nxt_idle), .done_q(done), .irq_q(done_irq)
  );

  wfs_pins #(.DW(DW), .CW(CW)) u_pins (
    .clk(clk), .rst(rst), .idle(nxt_idle), .st_data(st_data), .st_drv(st_drv),
    .st_ctl(st_ctl), .cfg_drv(cfg_drv), .cfg_rel(cfg_rel), .idle_ctl(idle_ctl),
    .od_mask(od_mask), .bus_out(bus_out), .bus_oe(bus_oe), .ctl_out(ctl_out),
    .ctl_oe(ctl_oe)
  );
endmodule

// File: rtl/wfs_engine_chk.sv
module wfs_engine_chk
  import wfs_pkg::*;
#(
  parameter int CW = 6,
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic          go,
  input logic          done,
  input logic          done_irq,
  input logic          wr_err,
  input logic          bus_oe,
  input logic [CW-1:0] ctl_out,
  input logic          cfg_drv,
  input logic [CW-1:0] od_mask
);
  assert_start_R3: assert property (@(posedge clk) disable iff (rst)
    (go && done) |=> !done);

  assert_irq_in_idle_R4: assert property (@(posedge clk) disable iff (rst)
    done_irq |-> done);

  assert_abort_ends_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == AW'(A_ABORT) && !done) |=> (done && done_irq));

  assert_lockout_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !done && wr_addr != AW'(A_ABORT)) |=> wr_err);

  assert_idle_bus_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> (bus_oe == $past(cfg_drv)));

  assert_open_drain_low_R12: assert property (@(posedge clk) disable iff (rst)
    (ctl_out & $past(od_mask)) == '0);

  assert_single_irq_R13: assert property (@(posedge clk) disable iff (rst)
    done_irq |=> !done_irq);
endmodule

bind wfs_engine wfs_engine_chk #(.CW(CW), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .go(go),
  .done(done), .done_irq(done_irq), .wr_err(wr_err), .bus_oe(bus_oe),
  .ctl_out(ctl_out), .cfg_drv(cfg_drv), .od_mask(od_mask)
);

// File: tb/wfs_engine_bench.sv
module wfs_engine_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        go = 1'b0;
  logic [15:0] bus_out;
  logic        bus_oe;
  logic [5:0]  ctl_out, ctl_oe;
  logic        done, done_irq, wr_err;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  // bench model
  logic [15:0] m_data [7];
  logic        m_drv  [7];
  logic [5:0]  m_ctl  [7];
  int          m_next [7];
  logic        m_cdrv = 0, m_rel = 0;
  logic [5:0]  m_ictl = '0, m_od = '0;
  logic [15:0] m_last = '0;
  logic        m_err = 0;

  always #5 clk = ~clk;

  wfs_engine u_wfs_engine (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .go(go), .bus_out(bus_out), .bus_oe(bus_oe), .ctl_out(ctl_out),
    .ctl_oe(ctl_oe), .done(done), .done_irq(done_irq), .wr_err(wr_err)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] f_out(input logic [5:0] lvl);
    return lvl & ~m_od;
  endfunction

  function automatic logic [5:0] f_oe(input logic [5:0] lvl);
    return ~(lvl & m_od);
  endfunction

  // called at a negedge; the write lands on the next rising edge
  task automatic wr(input int a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = 5'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic check_idle(input string req);
    chk(done == 1'b1, {req, " done"}, 32'(done), 1);
    chk(bus_oe == m_cdrv, "R8 idle bus_oe", 32'(bus_oe), 32'(m_cdrv));
    if (m_cdrv) chk(bus_out == m_last, "R9 idle bus_out", 32'(bus_out), 32'(m_last));
    if (m_rel) begin
      chk(ctl_oe == 6'd0, "R11 ctl_oe", 32'(ctl_oe), 0);
      chk(ctl_out == 6'd0, "R11 ctl_out", 32'(ctl_out), 0);
    end else begin
      chk(ctl_out == f_out(m_ictl), "R10 ctl_out", 32'(ctl_out), 32'(f_out(m_ictl)));
      chk(ctl_oe == f_oe(m_ictl), "R12 ctl_oe", 32'(ctl_oe), 32'(f_oe(m_ictl)));
    end
  endtask

  task automatic check_state(input int s);
    chk(done == 1'b0, "R3 busy", 32'(done), 0);
    chk(done_irq == 1'b0, "R4 no irq", 32'(done_irq), 0);
    chk(bus_oe == m_drv[s], "R4 state bus_oe", 32'(bus_oe), 32'(m_drv[s]));
    if (m_drv[s]) chk(bus_out == m_data[s], "R4 state bus_out", 32'(bus_out), 32'(m_data[s]));
    chk(ctl_out == f_out(m_ctl[s]), "R12 state ctl_out", 32'(ctl_out), 32'(f_out(m_ctl[s])));
    chk(ctl_oe == f_oe(m_ctl[s]), "R12 state ctl_oe", 32'(ctl_oe), 32'(f_oe(m_ctl[s])));
  endtask

  task automatic set_cfg(input logic drv, input logic rel, input logic [5:0] ictl, input logic [5:0] od);
    wr(0, {14'd0, rel, drv});
    wr(1, {10'd0, ictl});
    wr(2, {10'd0, od});
    m_cdrv = drv; m_rel = rel; m_ictl = ictl; m_od = od;
    @(negedge clk);
    check_idle("R2 cfg");
  endtask

  task automatic load_prog();
    for (int s = 0; s < 7; s++) begin
      wr(8 + 2 * s, m_data[s]);
      wr(9 + 2 * s, {6'd0, m_ctl[s], m_drv[s], 3'(m_next[s])});
    end
  endtask

  // go_at / wr_at / ab_at: cycle index inside the waveform, -1 for none
  task automatic run(input int go_at, input int wr_at, input int ab_at);
    int s = 0;
    int cyc = 0;
    go = 1'b1;
    @(negedge clk);
    go = 1'b0;
    forever begin
      check_state(s);
      if (m_drv[s]) m_last = m_data[s];
      if (cyc == ab_at) begin
        wr_en = 1'b1; wr_addr = 5'd3;
        @(negedge clk);
        wr_en = 1'b0;
        break;
      end
      if (cyc == go_at) go = 1'b1;
      if (cyc == wr_at) begin
        wr_en = 1'b1; wr_addr = 5'd1; wr_data = 16'($urandom);
        m_err = 1'b1;
      end
      s = m_next[s];
      cyc++;
      @(negedge clk);
      go = 1'b0; wr_en = 1'b0;
      if (s == 7 || cyc > 60) break;
    end
    chk(done == 1'b1, "R4/R6 end done", 32'(done), 1);
    chk(done_irq == 1'b1, "R4/R6 end irq", 32'(done_irq), 1);
    check_idle("R4 end");
    @(negedge clk);
    chk(done_irq == 1'b0, "R13 single irq", 32'(done_irq), 0);
    chk(wr_err == m_err, "R7 wr_err", 32'(wr_err), 32'(m_err));
    if (m_err) begin
      wr(4, 16'd0);
      m_err = 1'b0;
      chk(wr_err == 1'b0, "R7 clear", 32'(wr_err), 0);
    end
    check_idle("R7 after");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(done == 1'b1, "R1 done", 32'(done), 1);
    chk(done_irq == 1'b0, "R1 irq", 32'(done_irq), 0);
    chk(bus_oe == 1'b0, "R1 bus_oe", 32'(bus_oe), 0);
    chk(ctl_out == 6'd0, "R1 ctl_out", 32'(ctl_out), 0);
    chk(ctl_oe == 6'h3f, "R1 ctl_oe", 32'(ctl_oe), 32'h3f);
    chk(wr_err == 1'b0, "R1 wr_err", 32'(wr_err), 0);

    // R5/R6/R7: looping program, go and a refused write mid-run, then abort
    for (int s = 0; s < 7; s++) begin
      m_data[s] = 16'h1000 + 16'(s); m_drv[s] = 1'b1; m_ctl[s] = 6'(s + 1); m_next[s] = 7;
    end
    m_next[0] = 1; m_next[1] = 2; m_next[2] = 1;
    load_prog();
    set_cfg(1'b1, 1'b0, 6'h15, 6'h03);
    run(3, 4, 6);

    // R6 abort while idle does nothing
    wr(3, 16'd0);
    chk(done_irq == 1'b0, "R6 idle abort irq", 32'(done_irq), 0);
    chk(wr_err == 1'b0, "R6 idle abort err", 32'(wr_err), 0);
    check_idle("R6 idle abort");

    // R13 abort coinciding with branch to idle
    m_next[0] = 7;
    wr(9, {6'd0, m_ctl[0], m_drv[0], 3'd7});
    run(-1, -1, 0);

    // R9 non-driving state keeps the last driven value
    m_data[0] = 16'hA5A5; m_drv[0] = 1'b1; m_next[0] = 1;
    m_data[1] = 16'h1234; m_drv[1] = 1'b0; m_next[1] = 7;
    load_prog();
    set_cfg(1'b1, 1'b0, 6'h2a, 6'h00);
    run(-1, -1, -1);
    chk(bus_out == 16'hA5A5, "R9 held value", 32'(bus_out), 32'hA5A5);

    // random programs and idle configurations
    for (int it = 0; it < 40; it++) begin
      for (int s = 0; s < 7; s++) begin
        m_data[s] = 16'($urandom);
        m_drv[s]  = 1'($urandom);
        m_ctl[s]  = 6'($urandom);
        m_next[s] = s + 1 + int'($urandom % (7 - s));
      end
      load_prog();
      set_cfg(1'($urandom), 1'($urandom), 6'($urandom), 6'($urandom));
      run(int'($urandom % 4), (it % 3 == 0) ? int'($urandom % 3) : -1,
          (it % 4 == 1) ? int'($urandom % 3) : -1);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule